// File: doc/BRIEF.md
# Display Interrupt Status Unit

This block collects the interrupt sources of a multi-channel display controller. It has two sticky status words, two mask words and an interrupt-ID register, and it drives one registered interrupt line. Each channel reports start-of-frame, end-of-frame and branch events as single-cycle pulses. A bus error arrives as a pulse with a 3-bit channel number. The controller itself reports last-frame-done, input underrun on channels 0 and 1, and output underrun. A quick-disable-done event is raised inside the block when software clears the enable bit.

A status bit latches whether or not its mask bit is set. Software clears status bits by writing ones to them. When a channel event is unmasked and the interrupt line is still low, the interrupt-ID register captures the frame ID of that channel. If the line is already high, a subsequent-interrupt flag is set instead and the ID is left as it was. The block is used as the interrupt front end beside the descriptor-fetch and pixel engines, which produce the event pulses.

Top module: `disp_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads zero and `irq` is low.
- R2: Events set status bits whatever the masks are. In status word 0, channel 0 uses bit 1 for start-of-frame, bit 8 for end-of-frame and bit 9 for branch. Bit 0 is last-frame-done, bits 4 and 5 are input underrun for channels 0 and 1, and bit 6 is output underrun. For channel c from 1 to 6, status word 1 uses bit c-1 for start-of-frame, bit c+7 for end-of-frame and bit c+15 for branch.
- R3: `irq` is registered and goes high one cycle after an unmasked status bit. Mask bits: control word bits 4, 6 and 20 mask channel 0 start-of-frame, end-of-frame and branch; bit 3 masks last-frame-done, bit 5 input underrun 0, bit 21 output underrun and bit 11 quick-disable-done. The mask word uses the layout of status word 1, and its bit 24 masks input underrun 1.
- R4: An unmasked channel event, or any bus error, that occurs while `irq` is low loads the frame ID of its channel into the ID register. If several occur in one cycle, the lowest channel wins. Masked events leave the ID unchanged.
- R5: An unmasked channel event, or any bus error, that occurs while `irq` is high sets status word 0 bit 10 and leaves the ID unchanged.
- R6: A bus error sets status word 0 bit 2 and writes its channel number into bits 30:28 whatever the masks are. It does not raise `irq` by itself.
- R7: Writing status word 0 clears the ones in write data bits 11:0. A one in bit 2 also clears the channel field. Write bits above bit 11 have no effect.
- R8: Writing status word 1 clears only the ones that also lie in 0x003E3F3F. As a result, branch bit 16 of channel 1 cannot be cleared by software.
- R9: A write to the control word that takes bit 0 (enable) from 1 to 0 sets status word 0 bit 7. Other control writes do not set it.
- R10: If an event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R11: The ID register is read-only. A write to its address changes nothing.
- R12: Register addresses are 0 for the control word (keeps bits 26:0), 1 for the mask word (keeps 0x3F3F3F3F), 2 for status word 0, 3 for status word 1 and 4 for the ID. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_pls | input | NUM_CH | Start-of-frame pulse per channel |
| eof_pls | input | NUM_CH | End-of-frame pulse per channel |
| brn_pls | input | NUM_CH | Branch pulse per channel |
| berr_pls | input | 1 | Bus error pulse |
| berr_chan | input | 3 | Channel number of the bus error |
| last_done_pls | input | 1 | Last frame done pulse |
| in_urun_pls | input | 2 | Input underrun pulses, channels 0 and 1 |
| out_urun_pls | input | 1 | Output underrun pulse |
| frame_id_flat | input | NUM_CH*ID_W | Current frame ID of each channel, channel 0 in the low slice |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every channel against all three channel event kinds twice: once fully masked and once unmasked. The masked pass shows that bit placement is independent of masking and that masked events leave the ID and the interrupt line alone. The unmasked pass shows that each mask bit sits in the right place. For every channel, a second event after the line is high separates the capture path from the subsequent-interrupt path. Bus errors on every channel number check the field and confirm that the ID is captured while the line stays low. Directed cases cover coincident events (lowest channel wins), set against clear in one cycle, the uncleared branch bit of channel 1, and enable transitions in both directions.

// File: rtl/disp_irq_pkg.sv
// Package: register addresses, retention masks and bit positions shared by
// the display interrupt status unit and its submodules.
package disp_irq_pkg;
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_MASK = 3'd1;
    localparam logic [2:0] A_ST0  = 3'd2;
    localparam logic [2:0] A_ST1  = 3'd3;
    localparam logic [2:0] A_ID   = 3'd4;

    localparam logic [31:0] CTRL_KEEP = 32'h07FF_FFFF;
    localparam logic [31:0] MASK_KEEP = 32'h3F3F_3F3F;
    localparam logic [31:0] ST1_CLRABLE = 32'h003E_3F3F;

    // Status word 0 bit positions
    localparam int S_LAST = 0;
    localparam int S_SOF0 = 1;
    localparam int S_BERR = 2;
    localparam int S_IU0  = 4;
    localparam int S_IU1  = 5;
    localparam int S_OU   = 6;
    localparam int S_QD   = 7;
    localparam int S_EOF0 = 8;
    localparam int S_BRN0 = 9;
    localparam int S_SUBQ = 10;
    localparam int S_RDST = 11;
    localparam int S_CMD  = 12;
    localparam int S_FLD  = 28;

    // Control word bit positions
    localparam int C_EN    = 0;
    localparam int C_LASTM = 3;
    localparam int C_SOFM  = 4;
    localparam int C_IU0M  = 5;
    localparam int C_EOFM  = 6;
    localparam int C_QDM   = 11;
    localparam int C_BRNM  = 20;
    localparam int C_OUM   = 21;
    localparam int C_RDSTM = 23;
    localparam int C_CMDM  = 24;
    localparam int M_IU1M  = 24;

    // Status word 1 / mask word offsets per channel
    localparam int OFS_SOF = -1;
    localparam int OFS_EOF = 7;
    localparam int OFS_BRN = 15;
endpackage

// File: rtl/disp_irq_qual.sv
// Module: disp_irq_qual
// Decides which channel events count as unmasked and chooses the frame ID
// to capture. If the interrupt is already high, it raises the
// subsequent-interrupt flag instead. Assumes event pulses last one cycle and
// that a bus error channel number outside NUM_CH matches no channel.
module disp_irq_qual #(
    parameter int NUM_CH = 7,
    parameter int ID_W   = 32
) (
    input  logic [NUM_CH-1:0]      sof,
    input  logic [NUM_CH-1:0]      eof,
    input  logic [NUM_CH-1:0]      brn,
    input  logic [NUM_CH-1:0]      msk_sof,
    input  logic [NUM_CH-1:0]      msk_eof,
    input  logic [NUM_CH-1:0]      msk_brn,
    input  logic                   berr,
    input  logic [2:0]             berr_ch,
    input  logic [NUM_CH*ID_W-1:0] fid_flat,
    input  logic                   irq_now,
    output logic                   id_load,
    output logic [ID_W-1:0]        id_val,
    output logic                   subq_set
);
    logic [NUM_CH-1:0] hit;

    // Per-channel qualified hit; scanning downward lets the lowest channel win.
    always_comb begin
        hit    = (sof & ~msk_sof) | (eof & ~msk_eof) | (brn & ~msk_brn);
        id_val = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (berr && (int'(berr_ch) == c)) hit[c] = 1'b1;
            if (hit[c]) id_val = fid_flat[c*ID_W +: ID_W];
        end
    end

    // Steer the qualified event to ID capture or to the subsequent flag.
    always_comb begin
        id_load  = (|hit) && !irq_now;
        subq_set = (|hit) && irq_now;
    end
endmodule

// File: rtl/disp_irq_stat.sv
// Module: disp_irq_stat
// Holds the two sticky status words. Sets take priority over
// write-one-to-clear. Assumes the set vectors are built by the parent in the
// documented bit layout.
module disp_irq_stat
    import disp_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [12:0] set0,
    input  logic [31:0] set1,
    input  logic [11:0] clr0,
    input  logic [31:0] clr1,
    input  logic        berr,
    input  logic [2:0]  berr_ch,
    output logic [31:0] st0,
    output logic [31:0] st1
);
    logic [12:0] bits0_q;
    logic [2:0]  fld_q;
    logic [31:0] bits1_q;

    // Update the status bits; a set in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits0_q <= '0;
            fld_q   <= '0;
            bits1_q <= '0;
        end else begin
            bits0_q <= (bits0_q & ~{1'b0, clr0}) | set0;
            bits1_q <= (bits1_q & ~(clr1 & ST1_CLRABLE)) | set1;
            if (berr)          fld_q <= berr_ch;
            else if (clr0[S_BERR]) fld_q <= '0;
        end
    end

    // Pack the stored fields into the register image.
    always_comb begin
        st0 = {1'b0, fld_q, 15'b0, bits0_q};
        st1 = bits1_q;
    end

    assert_berr_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        berr |=> (st0[S_BERR] && st0[30:28] == $past(berr_ch)));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set0 != '0) |=> ((st0[12:0] & $past(set0)) == $past(set0)));

    assert_branch1_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st1[16] |=> st1[16]);
endmodule

// File: rtl/disp_irq_line.sv
// Module: disp_irq_line
// Registers the interrupt line: the OR of every status bit whose enable is
// set. Assumes the enables are already the inverted masks.
module disp_irq_line (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [12:0] st0,
    input  logic [12:0] en0,
    input  logic [31:0] st1,
    input  logic [31:0] msk1,
    output logic        irq
);
    // Recompute the interrupt level every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (|(st0 & en0)) || (|(st1 & ~msk1));
    end

    assert_quiet_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st0 == '0) && (st1 == '0)) |=> !irq);
endmodule

// File: rtl/disp_irq_unit.sv
// Module: disp_irq_unit
// Top of the display interrupt status unit: control, mask and ID registers,
// the register port, and wiring of the event vectors to the status and line
// logic. Assumes NUM_CH is at most 7, ID_W is at most 32, and event pulses
// are synchronous to clk.
module disp_irq_unit
    import disp_irq_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ID_W   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      sof_pls,
    input  logic [NUM_CH-1:0]      eof_pls,
    input  logic [NUM_CH-1:0]      brn_pls,
    input  logic                   berr_pls,
    input  logic [2:0]             berr_chan,
    input  logic                   last_done_pls,
    input  logic [1:0]             in_urun_pls,
    input  logic                   out_urun_pls,
    input  logic [NUM_CH*ID_W-1:0] frame_id_flat,
    input  logic                   reg_we,
    input  logic [2:0]             reg_waddr,
    input  logic [31:0]            reg_wdata,
    input  logic [2:0]             reg_raddr,
    output logic [31:0]            reg_rdata,
    output logic                   irq
);
    logic [31:0]       ctrl_q, mask_q;
    logic [ID_W-1:0]   id_q;
    logic [NUM_CH-1:0] m_sof, m_eof, m_brn;
    logic [12:0]       set0, en0;
    logic [31:0]       set1, st0_w, st1_w;
    logic [11:0]       clr0;
    logic [31:0]       clr1;
    logic              id_load, subq_set, qd_set;
    logic [ID_W-1:0]   id_val;

    // Channel 0 masks live in the control word; the others in the mask word.
    assign m_sof[0] = ctrl_q[C_SOFM];
    assign m_eof[0] = ctrl_q[C_EOFM];
    assign m_brn[0] = ctrl_q[C_BRNM];
    for (genvar c = 1; c < NUM_CH; c++) begin : g_chmask
        assign m_sof[c] = mask_q[c + OFS_SOF];
        assign m_eof[c] = mask_q[c + OFS_EOF];
        assign m_brn[c] = mask_q[c + OFS_BRN];
    end

    // Quick-disable done: the enable bit is written from 1 to 0.
    assign qd_set = reg_we && (reg_waddr == A_CTRL) && ctrl_q[C_EN] && !reg_wdata[C_EN];

    // Build the status set/clear vectors and the word-0 enables.
    always_comb begin
        set0 = '0;
        set0[S_LAST] = last_done_pls;
        set0[S_SOF0] = sof_pls[0];
        set0[S_BERR] = berr_pls;
        set0[S_IU0]  = in_urun_pls[0];
        set0[S_IU1]  = in_urun_pls[1];
        set0[S_OU]   = out_urun_pls;
        set0[S_QD]   = qd_set;
        set0[S_EOF0] = eof_pls[0];
        set0[S_BRN0] = brn_pls[0];
        set0[S_SUBQ] = subq_set;
        set1 = '0;
        for (int c = 1; c < NUM_CH; c++) begin
            set1[c + OFS_SOF] = sof_pls[c];
            set1[c + OFS_EOF] = eof_pls[c];
            set1[c + OFS_BRN] = brn_pls[c];
        end
        en0 = '0;
        en0[S_LAST] = !ctrl_q[C_LASTM];
        en0[S_SOF0] = !ctrl_q[C_SOFM];
        en0[S_IU0]  = !ctrl_q[C_IU0M];
        en0[S_IU1]  = !mask_q[M_IU1M];
        en0[S_OU]   = !ctrl_q[C_OUM];
        en0[S_QD]   = !ctrl_q[C_QDM];
        en0[S_EOF0] = !ctrl_q[C_EOFM];
        en0[S_BRN0] = !ctrl_q[C_BRNM];
        en0[S_RDST] = !ctrl_q[C_RDSTM];
        en0[S_CMD]  = !ctrl_q[C_CMDM];
        clr0 = (reg_we && reg_waddr == A_ST0) ? reg_wdata[11:0] : '0;
        clr1 = (reg_we && reg_waddr == A_ST1) ? reg_wdata : '0;
    end

    // Control, mask and ID registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
            id_q   <= '0;
        end else begin
            if (reg_we && reg_waddr == A_CTRL) ctrl_q <= reg_wdata & CTRL_KEEP;
            if (reg_we && reg_waddr == A_MASK) mask_q <= reg_wdata & MASK_KEEP;
            if (id_load) id_q <= id_val;
        end
    end

    // Combinational register read mux.
    always_comb begin
        case (reg_raddr)
            A_CTRL:  reg_rdata = ctrl_q;
            A_MASK:  reg_rdata = mask_q;
            A_ST0:   reg_rdata = st0_w;
            A_ST1:   reg_rdata = st1_w;
            A_ID:    reg_rdata = 32'(id_q);
            default: reg_rdata = '0;
        endcase
    end

    disp_irq_qual #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_qual (
        .sof(sof_pls), .eof(eof_pls), .brn(brn_pls),
        .msk_sof(m_sof), .msk_eof(m_eof), .msk_brn(m_brn),
        .berr(berr_pls), .berr_ch(berr_chan), .fid_flat(frame_id_flat),
        .irq_now(irq), .id_load(id_load), .id_val(id_val), .subq_set(subq_set)
    );

    disp_irq_stat u_stat (
        .clk(clk), .rst_n(rst_n), .set0(set0), .set1(set1),
        .clr0(clr0), .clr1(clr1), .berr(berr_pls), .berr_ch(berr_chan),
        .st0(st0_w), .st1(st1_w)
    );

    disp_irq_line u_line (
        .clk(clk), .rst_n(rst_n), .st0(st0_w[12:0]), .en0(en0),
        .st1(st1_w), .msk1(mask_q), .irq(irq)
    );

    assert_irq_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(st0_w[12:0] != '0 || st1_w != '0));

    assert_id_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !id_load |=> $stable(id_q));

    assert_qd_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        qd_set |=> st0_w[S_QD]);
endmodule

// File: tb/disp_irq_unit_bench.sv
`timescale 1ns/1ps
module disp_irq_unit_bench;
    localparam int NCH = 7;
    localparam int IDW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] sof = '0, eof = '0, brn = '0;
    logic berr = 1'b0;
    logic [2:0] bch = '0;
    logic last_done = 1'b0, ou = 1'b0;
    logic [1:0] iu = '0;
    logic [NCH*IDW-1:0] fid = '0;
    logic we = 1'b0;
    logic [2:0] waddr = '0, raddr = '0;
    logic [31:0] wdata = '0, rdata;
    logic irq;
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    disp_irq_unit #(.NUM_CH(NCH), .ID_W(IDW)) u_disp_irq_unit (
        .clk(clk), .rst_n(rst_n), .sof_pls(sof), .eof_pls(eof), .brn_pls(brn),
        .berr_pls(berr), .berr_chan(bch), .last_done_pls(last_done),
        .in_urun_pls(iu), .out_urun_pls(ou), .frame_id_flat(fid),
        .reg_we(we), .reg_waddr(waddr), .reg_wdata(wdata),
        .reg_raddr(raddr), .reg_rdata(rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        raddr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        we = 1'b1; waddr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Pulse one channel event: kind 0 start, 1 end, 2 branch.
    task automatic pulse(int kind, int c);
        if (kind == 0) sof[c] = 1'b1;
        else if (kind == 1) eof[c] = 1'b1;
        else brn[c] = 1'b1;
        @(negedge clk);
        sof = '0; eof = '0; brn = '0;
    endtask

    function automatic int bitpos(int kind, int c);
        if (c == 0) return (kind == 0) ? 1 : (kind == 1) ? 8 : 9;
        return (kind == 0) ? c - 1 : (kind == 1) ? c + 7 : c + 15;
    endfunction

    initial begin
        logic [31:0] v, v1;
        for (int c = 0; c < NCH; c++) fid[c*IDW +: IDW] = 32'hA500_0000 + 32'(c * 17 + 3);
        @(negedge clk);
        do_reset();
        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 reset irq", 32'(irq), 32'h0);

        // R2/R3/R8/R7: sweep channels and kinds, masked then unmasked
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 3; k++) begin
                do_reset();
                wr(3'd0, 32'h0010_0050);
                wr(3'd1, 32'h3F3F_3F3F);
                pulse(k, c);
                rd(3'd2, v); rd(3'd3, v1);
                chk("R2 status0 masked event", v, (c == 0) ? (32'h1 << bitpos(k, c)) : 32'h0);
                chk("R2 status1 masked event", v1, (c == 0) ? 32'h0 : (32'h1 << bitpos(k, c)));
                @(negedge clk);
                chk("R3 masked irq low", 32'(irq), 32'h0);
                rd(3'd4, v);
                chk("R4 masked leaves id", v, 32'h0);
                wr(3'd0, 32'h0);
                wr(3'd1, 32'h0);
                @(negedge clk);
                chk("R3 unmask raises irq", 32'(irq), 32'h1);
                wr((c == 0) ? 3'd2 : 3'd3, 32'hFFFF_FFFF);
                rd((c == 0) ? 3'd2 : 3'd3, v);
                chk((c == 1 && k == 2) ? "R8 branch1 sticky" : "R7 clear by ones", v,
                    (c == 1 && k == 2) ? 32'h0001_0000 : 32'h0);
                if (!(c == 1 && k == 2)) begin
                    @(negedge clk);
                    chk("R3 irq drops after clear", 32'(irq), 32'h0);
                end
            end
        end

        // R4/R5: capture then subsequent flag per channel
        for (int c = 0; c < NCH; c++) begin
            do_reset();
            pulse(0, c);
            rd(3'd4, v);
            chk("R4 id captured", v, 32'hA500_0000 + 32'(c * 17 + 3));
            @(negedge clk);
            chk("R3 irq after event", 32'(irq), 32'h1);
            pulse(1, (c + 1) % NCH);
            rd(3'd2, v);
            chk("R5 subsequent flag", 32'(v[10]), 32'h1);
            rd(3'd4, v);
            chk("R5 id unchanged", v, 32'hA500_0000 + 32'(c * 17 + 3));
        end

        // R4: two channels at once, lowest wins
        do_reset();
        sof[3] = 1'b1; sof[5] = 1'b1;
        @(negedge clk);
        sof = '0;
        rd(3'd4, v);
        chk("R4 lowest channel wins", v, 32'hA500_0000 + 32'(3 * 17 + 3));

        // R6/R7: bus errors on every channel number, masks all set
        for (int k = 0; k < NCH; k++) begin
            do_reset();
            wr(3'd0, 32'h07FF_FFFE);
            wr(3'd1, 32'h3F3F_3F3F);
            berr = 1'b1; bch = 3'(k);
            @(negedge clk);
            berr = 1'b0;
            rd(3'd2, v);
            chk("R6 error bit and field", v, 32'h4 | (32'(k) << 28));
            rd(3'd4, v);
            chk("R6 error captures id", v, 32'hA500_0000 + 32'(k * 17 + 3));
            repeat (2) @(negedge clk);
            chk("R6 error no irq", 32'(irq), 32'h0);
            wr(3'd2, 32'hF000_0000);
            rd(3'd2, v);
            chk("R7 high bits ignored", v, 32'h4 | (32'(k) << 28));
            wr(3'd2, 32'h4);
            rd(3'd2, v);
            chk("R7 error clear drops field", v, 32'h0);
        end

        // R2/R3: controller events and their masks
        do_reset();
        last_done = 1'b1; iu = 2'b11; ou = 1'b1;
        @(negedge clk);
        last_done = 1'b0; iu = '0; ou = 1'b0;
        rd(3'd2, v);
        chk("R2 controller event bits", v, 32'h71);
        @(negedge clk);
        chk("R3 controller irq", 32'(irq), 32'h1);
        wr(3'd0, 32'h0020_0028);
        wr(3'd1, 32'h0100_0000);
        @(negedge clk);
        chk("R3 controller masks", 32'(irq), 32'h0);

        // R9/R12: enable transitions and control readback
        do_reset();
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v);
        chk("R12 control keeps 26:0", v, 32'h07FF_FFFF);
        rd(3'd2, v);
        chk("R9 no flag on enable", v, 32'h0);
        wr(3'd0, 32'h0);
        rd(3'd2, v);
        chk("R9 flag on disable", v, 32'h80);
        wr(3'd2, 32'h80);
        wr(3'd0, 32'h0);
        rd(3'd2, v);
        chk("R9 no flag 0 to 0", v, 32'h0);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v);
        chk("R12 mask keeps pattern", v, 32'h3F3F_3F3F);

        // R10: set beats clear in the same cycle
        do_reset();
        eof[0] = 1'b1; brn[2] = 1'b1;
        we = 1'b1; waddr = 3'd2; wdata = 32'h100;
        @(negedge clk);
        eof = '0; brn = '0; we = 1'b0;
        rd(3'd2, v);
        chk("R10 set wins status0", v, 32'h100);
        brn[2] = 1'b1;
        we = 1'b1; waddr = 3'd3; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        brn = '0; we = 1'b0;
        rd(3'd3, v);
        chk("R10 set wins status1", v, 32'h0002_0000);

        // R11: ID register ignores writes
        rd(3'd4, v1);
        wr(3'd4, 32'hDEAD_BEEF);
        rd(3'd4, v);
        chk("R11 id write ignored", v, v1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule